// File: doc/BRIEF.md
# Segment Descriptor Translation Unit

This block converts a segment-relative access into a 32-bit linear address. It keeps one cached descriptor for each of six segment registers. When a new selector is written into a register, the block reads the matching 8-byte descriptor from a table in memory. It does this in two 32-bit reads on a simple request/response port. The fetched descriptor replaces the cached entry for that register.

A translation names a register and gives a 32-bit offset and a write flag. One cycle after acceptance the block returns a registered response. The response holds either the descriptor base plus the offset, or a 2-bit fault code with a zero address. The limit check, write-protect check and presence check all run in parallel with the address adder.

Only the register being refilled stalls. Translations through the other registers continue while the fetch is in flight. Several registers can be loaded at the same time; their fetches queue and are served lowest index first.

Top module: `seg_xlate`

## Requirements
- R1: After reset every cache entry is invalid. A translation through a register never loaded since reset, or through a register id of 6 or 7, returns fault code 3 (not present).
- R2: A descriptor fetch issues two single-cycle read requests. The first is at table base + selector*8 and returns the low word. The second is at that address + 4 and returns the high word. Each read waits for `mem_rvalid`, which may arrive any number of cycles later.
- R3: Descriptor layout: bits [31:0] base, [51:32] limit, bit 52 granularity, bit 53 writable, bit 54 present. A cleared present bit gives fault code 3.
- R4: An accepted translation (`tr_valid` and `tr_ready` high) gives `rsp_valid` exactly one cycle later. With fault code 0 the address is base + offset modulo 2^32. With any nonzero fault the address is 0.
- R5: With granularity 0 the limit counts bytes. An offset greater than the limit gives fault code 1; an offset equal to it does not.
- R6: With granularity 1 the effective limit is (limit << 12) | 0xFFF. A descriptor with base 0, limit 0xFFFFF and granularity 1 never gives a limit fault.
- R7: A write through a descriptor with writable = 0 gives fault code 2, and a read through it gives none. When several faults apply, not present (3) wins over limit (1), and limit wins over write (2).
- R8: From the cycle after a register's selector is loaded until its descriptor is filled, `tr_ready` is low for that register id. Other loaded registers keep translating meanwhile.
- R9: Selectors loaded in the same cycle are fetched in ascending register order.
- R10: Reloading a register while its fetch is in flight leaves the register stalled until the newest selector's descriptor is in place. The newest descriptor is the one used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 6 | Per-register selector load strobe |
| ld_sel | input | 72 | Selector per register, 12 bits each, register k at [12k+11:12k] |
| tbl_base | input | 32 | Descriptor table base address |
| tr_valid | input | 1 | Translation request |
| tr_seg | input | 3 | Register id, 0 to 5 |
| tr_off | input | 32 | Offset within the segment |
| tr_wr | input | 1 | Access is a write |
| tr_ready | output | 1 | Request for tr_seg can be accepted |
| rsp_valid | output | 1 | Translation result valid |
| rsp_fault | output | 2 | 0 none, 1 limit, 2 write, 3 not present |
| rsp_addr | output | 32 | Linear address, 0 on fault |
| mem_req | output | 1 | Single-cycle read request |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench probes offsets exactly at the limit and one past it, in both granularities. A design with an off-by-one compare, or one that forgets to fill the low 12 bits for page units, faults on the last legal byte or lets the first illegal one through. It also checks fault priority on a read-only segment accessed past its limit. It sends a base near the top of memory, where a wrong adder width would show up. It also tries an unloaded register, which would return garbage if the entry were not invalid after reset. Stalling is tested by translating through one register while another is being refilled under slow memory. Two further cases target the fetch queue: simultaneous loads must be fetched in register order, and a reload in mid-fetch must not leave the older descriptor in place.

// File: rtl/segx_pkg.sv
package segx_pkg;
  localparam int AW      = 32;
  localparam int WORD_W  = 32;
  localparam int LIM_W   = 20;
  localparam int PAGE_SH = 12;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_LIMIT  = 2'd1,
    FLT_WRITE  = 2'd2,
    FLT_ABSENT = 2'd3
  } fault_e;

  typedef struct packed {
    logic             present;
    logic             writable;
    logic             gran;
    logic [LIM_W-1:0] limit;
    logic [AW-1:0]    base;
  } desc_t;
endpackage

// File: rtl/segx_rst_sync.sv
module segx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/segx_fetch.sv
module segx_fetch
  import segx_pkg::*;
#(
  parameter int NSEG = 6,
  parameter int SELW = 12,
  parameter int SEGW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSEG-1:0]      ld_en,
  input  logic [NSEG*SELW-1:0] ld_sel,
  input  logic [AW-1:0]        tbl_base,
  output logic                 mem_req,
  output logic [AW-1:0]        mem_addr,
  input  logic                 mem_rvalid,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic                 fill_en,
  output logic [SEGW-1:0]      fill_idx,
  output desc_t                fill_desc,
  output logic [NSEG-1:0]      busy
);
  localparam int PADW = AW - SELW - 3;

  typedef enum logic [2:0] {
    F_IDLE, F_REQ_LO, F_WAIT_LO, F_REQ_HI, F_WAIT_HI
  } fstate_e;

  fstate_e            state_q, state_d;
  logic [NSEG-1:0]    pend_q, pend_d, pick_oh;
  logic [SELW-1:0]    sel_q [NSEG];
  logic [SEGW-1:0]    cur_q, cur_d, pick_idx;
  logic [SELW-1:0]    cur_sel_q, cur_sel_d, pick_sel;
  logic [WORD_W-1:0]  lo_q, lo_d;
  logic               lo_en, cur_en;

  // per-register selector holding registers
  for (genvar k = 0; k < NSEG; k++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sel_q[k] <= '0;
      else if (ld_en[k]) sel_q[k] <= ld_sel[k*SELW +: SELW];
    end
  end

  // lowest pending register wins
  always_comb begin
    pick_idx = '0;
    pick_sel = '0;
    pick_oh  = '0;
    for (int k = NSEG - 1; k >= 0; k--) begin
      if (pend_q[k]) begin
        pick_idx    = SEGW'(k);
        pick_sel    = sel_q[k];
        pick_oh     = '0;
        pick_oh[k]  = 1'b1;
      end
    end
  end

  always_comb begin
    state_d   = state_q;
    cur_d     = cur_q;
    cur_sel_d = cur_sel_q;
    cur_en    = 1'b0;
    lo_d      = mem_rdata;
    lo_en     = 1'b0;
    mem_req   = 1'b0;
    fill_en   = 1'b0;
    pend_d    = pend_q | ld_en;
    unique case (state_q)
      F_IDLE: if (|pend_q) begin
        state_d   = F_REQ_LO;
        cur_d     = pick_idx;
        cur_sel_d = pick_sel;
        cur_en    = 1'b1;
        pend_d    = (pend_q & ~pick_oh) | ld_en;
      end
      F_REQ_LO: begin
        mem_req = 1'b1;
        state_d = F_WAIT_LO;
      end
      F_WAIT_LO: if (mem_rvalid) begin
        lo_en   = 1'b1;
        state_d = F_REQ_HI;
      end
      F_REQ_HI: begin
        mem_req = 1'b1;
        state_d = F_WAIT_HI;
      end
      F_WAIT_HI: if (mem_rvalid) begin
        fill_en = 1'b1;
        state_d = F_IDLE;
      end
      default: state_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= F_IDLE;
      pend_q  <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q     <= '0;
      cur_sel_q <= '0;
    end else if (cur_en) begin
      cur_q     <= cur_d;
      cur_sel_q <= cur_sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_en) lo_q <= lo_d;
  end

  assign mem_addr = tbl_base + {{PADW{1'b0}}, cur_sel_q, 3'b000}
                  + ((state_q == F_REQ_HI) ? AW'(4) : AW'(0));

  assign fill_idx            = cur_q;
  assign fill_desc.base      = lo_q;
  assign fill_desc.limit     = mem_rdata[LIM_W-1:0];
  assign fill_desc.gran      = mem_rdata[LIM_W];
  assign fill_desc.writable  = mem_rdata[LIM_W+1];
  assign fill_desc.present   = mem_rdata[LIM_W+2];

  always_comb begin
    for (int k = 0; k < NSEG; k++)
      busy[k] = pend_q[k] | ((state_q != F_IDLE) && (cur_q == SEGW'(k)));
  end
endmodule

// File: rtl/segx_cache.sv
module segx_cache
  import segx_pkg::*;
#(
  parameter int NSEG = 6,
  parameter int SEGW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fill_en,
  input  logic [SEGW-1:0] fill_idx,
  input  desc_t           fill_desc,
  input  logic [SEGW-1:0] rd_idx,
  output desc_t           rd_desc,
  output logic            rd_valid
);
  desc_t           ent_q [NSEG];
  logic [NSEG-1:0] val_q;

  for (genvar k = 0; k < NSEG; k++) begin : g_ent
    logic we;
    assign we = fill_en && (fill_idx == SEGW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[k] <= '0;
        val_q[k] <= 1'b0;
      end else if (we) begin
        ent_q[k] <= fill_desc;
        val_q[k] <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_desc  = '0;
    rd_valid = 1'b0;
    for (int k = 0; k < NSEG; k++) begin
      if (rd_idx == SEGW'(k)) begin
        rd_desc  = ent_q[k];
        rd_valid = val_q[k];
      end
    end
  end
endmodule

// File: rtl/segx_check.sv
module segx_check
  import segx_pkg::*;
(
  input  desc_t         desc,
  input  logic          valid,
  input  logic [AW-1:0] off,
  input  logic          wr,
  output fault_e        fault,
  output logic [AW-1:0] lin
);
  logic [AW-1:0] eff_lim;
  logic [AW-1:0] sum;

  assign eff_lim = desc.gran ? {desc.limit, {PAGE_SH{1'b1}}}
                             : {{(AW-LIM_W){1'b0}}, desc.limit};
  assign sum = desc.base + off;

  always_comb begin
    if (!valid || !desc.present)      fault = FLT_ABSENT;
    else if (off > eff_lim)           fault = FLT_LIMIT;
    else if (wr && !desc.writable)    fault = FLT_WRITE;
    else                              fault = FLT_NONE;
  end

  assign lin = (fault == FLT_NONE) ? sum : '0;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import segx_pkg::*;
#(
  parameter int NSEG = 6,
  parameter int SELW = 12,
  parameter int SEGW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSEG-1:0]      ld_en,
  input  logic [NSEG*SELW-1:0] ld_sel,
  input  logic [31:0]          tbl_base,
  input  logic                 tr_valid,
  input  logic [SEGW-1:0]      tr_seg,
  input  logic [31:0]          tr_off,
  input  logic                 tr_wr,
  output logic                 tr_ready,
  output logic                 rsp_valid,
  output logic [1:0]           rsp_fault,
  output logic [31:0]          rsp_addr,
  output logic                 mem_req,
  output logic [31:0]          mem_addr,
  input  logic                 mem_rvalid,
  input  logic [31:0]          mem_rdata
);
  localparam int NIDX = 1 << SEGW;

  logic            srst_n;
  logic            fill_en;
  logic [SEGW-1:0] fill_idx;
  desc_t           fill_desc;
  logic [NSEG-1:0] busy;
  logic [NIDX-1:0] busy_ext;
  desc_t           rd_desc;
  logic            rd_valid;
  fault_e          chk_fault;
  logic [31:0]     chk_addr;
  logic            accept;

  segx_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  segx_fetch #(.NSEG(NSEG), .SELW(SELW), .SEGW(SEGW)) u_fetch (
    .clk(clk), .rst_n(srst_n), .ld_en(ld_en), .ld_sel(ld_sel),
    .tbl_base(tbl_base), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_desc(fill_desc),
    .busy(busy)
  );

  segx_cache #(.NSEG(NSEG), .SEGW(SEGW)) u_cache (
    .clk(clk), .rst_n(srst_n), .fill_en(fill_en), .fill_idx(fill_idx),
    .fill_desc(fill_desc), .rd_idx(tr_seg), .rd_desc(rd_desc),
    .rd_valid(rd_valid)
  );

  segx_check u_chk_path (
    .desc(rd_desc), .valid(rd_valid), .off(tr_off), .wr(tr_wr),
    .fault(chk_fault), .lin(chk_addr)
  );

  always_comb begin
    busy_ext           = '0;
    busy_ext[NSEG-1:0] = busy;
  end

  assign tr_ready = srst_n && !busy_ext[tr_seg];
  assign accept   = tr_valid && tr_ready;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rsp_valid <= 1'b0;
    else         rsp_valid <= accept;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rsp_fault <= 2'd0;
      rsp_addr  <= '0;
    end else if (accept) begin
      rsp_fault <= chk_fault;
      rsp_addr  <= chk_addr;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int NSEG = 6,
  parameter int SEGW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSEG-1:0] ld_en,
  input logic            tr_valid,
  input logic [SEGW-1:0] tr_seg,
  input logic            tr_wr,
  input logic            tr_ready,
  input logic            rsp_valid,
  input logic [1:0]      rsp_fault,
  input logic [31:0]     rsp_addr,
  input logic            mem_req
);
  p_rsp_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && tr_ready) |=> rsp_valid);

  p_no_rsp_without_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tr_valid && tr_ready) |=> !rsp_valid);

  p_fault_zero_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> rsp_addr == 32'd0);

  p_single_cycle_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_read_never_wp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && tr_ready && !tr_wr) |=> rsp_fault != 2'd2);

  for (genvar k = 0; k < NSEG; k++) begin : g_stall
    p_load_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en[k] |=> (tr_seg != SEGW'(k)) || !tr_ready);
  end
endmodule

bind seg_xlate seg_xlate_chk #(.NSEG(NSEG), .SEGW(SEGW)) u_xlate_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .tr_valid(tr_valid),
  .tr_seg(tr_seg), .tr_wr(tr_wr), .tr_ready(tr_ready),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr),
  .mem_req(mem_req)
);

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;
  localparam int NSEG = 6;
  localparam int SELW = 12;
  localparam logic [31:0] TBASE = 32'h0001_0000;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [NSEG-1:0]      ld_en;
  logic [NSEG*SELW-1:0] ld_sel;
  logic [31:0]          tbl_base;
  logic                 tr_valid, tr_wr, tr_ready;
  logic [2:0]           tr_seg;
  logic [31:0]          tr_off;
  logic                 rsp_valid;
  logic [1:0]           rsp_fault;
  logic [31:0]          rsp_addr;
  logic                 mem_req, mem_rvalid;
  logic [31:0]          mem_addr, mem_rdata;

  int checks = 0;
  int errors = 0;
  int lat_fix = -1;
  int req_cnt = 0;
  logic [31:0] req_log [8];
  logic [63:0] dmem [16];
  logic [63:0] mdl_desc [NSEG];
  logic        mdl_ok [NSEG];

  always #4 clk = ~clk;

  seg_xlate uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
    .tbl_base(tbl_base), .tr_valid(tr_valid), .tr_seg(tr_seg),
    .tr_off(tr_off), .tr_wr(tr_wr), .tr_ready(tr_ready),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [63:0] mk(logic [31:0] b, logic [19:0] l,
                                     logic g, logic w, logic p);
    return {9'd0, p, w, g, l, b};
  endfunction

  function automatic logic [1:0] efault(logic [63:0] d, logic ok,
                                        logic [31:0] off, logic wr);
    logic [31:0] lim;
    lim = d[52] ? {d[51:32], 12'hFFF} : {12'h000, d[51:32]};
    if (!ok || !d[54])       return 2'd3;
    if (off > lim)           return 2'd1;
    if (wr && !d[53])        return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [31:0] eaddr(logic [63:0] d, logic ok,
                                        logic [31:0] off, logic wr);
    return (efault(d, ok, off, wr) == 2'd0) ? d[31:0] + off : 32'd0;
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // memory responder: one response per request, at least one cycle later
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        logic [31:0] a;
        logic [31:0] rel;
        int lat;
        a = mem_addr;
        if (req_cnt < 8) req_log[req_cnt] = a;
        req_cnt++;
        lat = (lat_fix >= 0) ? lat_fix : int'($urandom % 4);
        repeat (1 + lat) @(negedge clk);
        rel = a - TBASE;
        mem_rvalid = 1'b1;
        mem_rdata  = rel[2] ? dmem[rel[6:3]][63:32] : dmem[rel[6:3]][31:0];
      end
    end
  end

  task automatic pulse_load(int s, logic [11:0] sel);
    @(negedge clk);
    ld_en[s] = 1'b1;
    ld_sel[s*SELW +: SELW] = sel;
    @(negedge clk);
    ld_en = '0;
    mdl_desc[s] = dmem[sel[3:0]];
    mdl_ok[s]   = 1'b1;
  endtask

  task automatic wait_ready(int s);
    int n = 0;
    tr_seg = 3'(s);
    #1;
    while (!tr_ready && n < 500) begin
      @(negedge clk);
      #1;
      n++;
    end
  endtask

  task automatic xlate(int s, logic [31:0] off, logic wr,
                       output logic [1:0] f, output logic [31:0] a,
                       output logic v);
    @(negedge clk);
    tr_valid = 1'b1;
    tr_seg   = 3'(s);
    tr_off   = off;
    tr_wr    = wr;
    #1;
    while (!tr_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    tr_valid = 1'b0;
    f = rsp_fault;
    a = rsp_addr;
    v = rsp_valid;
  endtask

  task automatic tcheck(string req, int s, logic [31:0] off, logic wr);
    logic [1:0]  f;
    logic [31:0] a;
    logic        v;
    xlate(s, off, wr, f, a, v);
    check(req, {31'd0, v}, 64'd1);
    check(req, {62'd0, f}, {62'd0, efault(mdl_desc[s], mdl_ok[s], off, wr)});
    check(req, {32'd0, a}, {32'd0, eaddr(mdl_desc[s], mdl_ok[s], off, wr)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0]  f;
    logic [31:0] a;
    logic        v;
    void'($urandom(32'd2718));
    dmem[0] = mk(32'h0000_0000, 20'hFFFFF, 1'b1, 1'b1, 1'b1);
    dmem[1] = mk(32'h4000_0000, 20'h00FFF, 1'b0, 1'b1, 1'b1);
    dmem[2] = mk(32'h8000_0000, 20'h00002, 1'b1, 1'b1, 1'b1);
    dmem[3] = mk(32'h1234_0000, 20'h0FFFF, 1'b0, 1'b0, 1'b1);
    dmem[4] = mk(32'h0000_5000, 20'hFFFFF, 1'b1, 1'b1, 1'b0);
    dmem[5] = mk(32'hFFFF_F000, 20'hFFFFF, 1'b1, 1'b1, 1'b1);
    for (int i = 6; i < 15; i++)
      dmem[i] = mk($urandom, 20'($urandom), 1'($urandom), 1'($urandom),
                   ($urandom % 5) != 0);
    dmem[15] = mk(32'h0000_1000, 20'h00010, 1'b0, 1'b1, 1'b1);
    for (int s = 0; s < NSEG; s++) begin
      mdl_desc[s] = '0;
      mdl_ok[s]   = 1'b0;
    end

    rst_n = 1'b0; ld_en = '0; ld_sel = '0; tbl_base = TBASE;
    tr_valid = 1'b0; tr_seg = '0; tr_off = '0; tr_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1 rsp_valid idle", {63'd0, rsp_valid}, 64'd0);
    check("R1 mem_req idle", {63'd0, mem_req}, 64'd0);
    tcheck("R1 unloaded", 1, 32'h10, 1'b0);
    xlate(7, 32'h0, 1'b0, f, a, v);
    check("R1 bad id", {62'd0, f}, 64'd3);

    // R2: fetch addresses for the highest selector, with wait states
    lat_fix = 3; req_cnt = 0;
    pulse_load(0, 12'hFFF);
    wait_ready(0);
    check("R2 req count", 64'(req_cnt), 64'd2);
    check("R2 low addr", {32'd0, req_log[0]}, {32'd0, TBASE + 32'h7FF8});
    check("R2 high addr", {32'd0, req_log[1]}, {32'd0, TBASE + 32'h7FFC});
    tcheck("R3 fetched desc", 0, 32'h10, 1'b1);
    tcheck("R5 past byte limit", 0, 32'h11, 1'b0);

    // R6: flat segment
    lat_fix = -1;
    pulse_load(1, 12'd0); wait_ready(1);
    tcheck("R6 flat top", 1, 32'hFFFF_FFFF, 1'b1);
    tcheck("R4 flat addr", 1, 32'h0BAD_CAFE, 1'b0);

    // R5: byte granularity boundary
    pulse_load(2, 12'd1); wait_ready(2);
    tcheck("R5 at limit", 2, 32'h0000_0FFF, 1'b0);
    tcheck("R5 over limit", 2, 32'h0000_1000, 1'b0);

    // R6: page granularity boundary
    pulse_load(3, 12'd2); wait_ready(3);
    tcheck("R6 at page limit", 3, 32'h0000_2FFF, 1'b1);
    tcheck("R6 over page limit", 3, 32'h0000_3000, 1'b1);

    // R7: write protect and priorities
    pulse_load(4, 12'd3); wait_ready(4);
    tcheck("R7 read ro", 4, 32'h100, 1'b0);
    tcheck("R7 write ro", 4, 32'h100, 1'b1);
    tcheck("R7 limit over write", 4, 32'h0001_0000, 1'b1);

    // R3: not present
    pulse_load(5, 12'd4); wait_ready(5);
    tcheck("R3 absent", 5, 32'h0, 1'b0);

    // R4: wrap of base plus offset
    pulse_load(5, 12'd5); wait_ready(5);
    tcheck("R4 wrap", 5, 32'h0000_2000, 1'b0);

    // R8: stall only the reloading register
    lat_fix = 6;
    pulse_load(2, 12'd15);
    tr_seg = 3'd2; #1;
    check("R8 stalled", {63'd0, tr_ready}, 64'd0);
    tcheck("R8 other continues", 1, 32'h1234, 1'b0);
    tr_seg = 3'd2; #1;
    check("R8 still stalled", {63'd0, tr_ready}, 64'd0);
    wait_ready(2);
    tcheck("R8 after fill", 2, 32'h8, 1'b0);

    // R9: simultaneous loads in ascending order
    lat_fix = 1; req_cnt = 0;
    @(negedge clk);
    ld_en = 6'b000011;
    ld_sel[0 +: SELW] = 12'd3;
    ld_sel[SELW +: SELW] = 12'd1;
    @(negedge clk);
    ld_en = '0;
    mdl_desc[0] = dmem[3]; mdl_ok[0] = 1'b1;
    mdl_desc[1] = dmem[1]; mdl_ok[1] = 1'b1;
    wait_ready(0); wait_ready(1);
    check("R9 first", {32'd0, req_log[0]}, {32'd0, TBASE + 32'd24});
    check("R9 third", {32'd0, req_log[2]}, {32'd0, TBASE + 32'd8});
    tcheck("R9 seg0", 0, 32'h4, 1'b0);
    tcheck("R9 seg1", 1, 32'h4, 1'b0);

    // R10: reload during fetch
    lat_fix = 4;
    pulse_load(3, 12'd1);
    @(negedge clk);
    pulse_load(3, 12'd2);
    tr_seg = 3'd3; #1;
    check("R10 stalled", {63'd0, tr_ready}, 64'd0);
    wait_ready(3);
    tcheck("R10 newest", 3, 32'h0000_2FFF, 1'b1);
    tcheck("R10 newest limit", 3, 32'h0000_3000, 1'b0);

    // random mix
    lat_fix = -1;
    for (int it = 0; it < 400; it++) begin
      int s;
      s = int'($urandom % NSEG);
      if (($urandom % 5) == 0) begin
        pulse_load(s, 12'($urandom % 16));
        wait_ready(s);
      end else begin
        logic [31:0] off;
        logic [31:0] lim;
        lim = mdl_desc[s][52] ? {mdl_desc[s][51:32], 12'hFFF}
                              : {12'h0, mdl_desc[s][51:32]};
        case ($urandom % 3)
          0: off = $urandom;
          1: off = lim;
          default: off = lim + 32'd1;
        endcase
        tcheck("R4 random", s, off, 1'($urandom));
      end
    end

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule